// File: doc/BRIEF.md
# DRAM Refresh and Power-State Sequencer

This block sits on the controller side of a DDR SDRAM interface. It keeps the periodic auto-refresh on schedule and drives the command sequences for self-refresh and power-down. A free-running interval timer, sized from the clock frequency and the average refresh period, says when a refresh is due. The block then takes the command slot and issues the refresh, but only once the main scheduler reports that every bank is idle. The host asks for self-refresh or power-down by holding a request level high. Dropping the request asks the block to wake the memory.

The block drives a three-bit command code and the clock-enable level. It also gives the main scheduler three grant flags: one for activate and mode-register commands, one for the other non-read commands, and one for reads. Each flag falls while a refresh recovery window or a wake-up window is still running. Reads wait longer than other commands after self-refresh exit, because the output timing must re-lock first. While powered down the memory does no refreshing of its own. The block therefore wakes the device by itself shortly before each refresh deadline, serves the refresh, and then returns to power-down if the host still asks for it.

Top module: `dram_pwr_refresh_seq`

## Requirements
- R1: After reset, `cmd` is NOP (0), `cke` is high, all three grants are high and `busy` is low.
- R2: With banks idle and no host request, a REF strobe (code 1) appears exactly REFI_CYC = REFI_NS*CLK_MHZ/1000 cycles after the previous REF or SELFX strobe. The first REF appears REFI_CYC cycles after reset.
- R3: In the REF cycle, all grants are low. `grant_nonrd` returns in the next cycle. `grant_act` returns exactly T_RFC cycles after the REF cycle, and `grant_rd` returns one cycle after that.
- R4: REF, SELF and PDEN are issued only in a cycle that follows a cycle with `banks_idle` high. While one of them is held back by busy banks, `busy` is high. The held-back command appears in the cycle after `banks_idle` is seen high again.
- R5: SELF (code 2) drives `cke` low in its own cycle. No REF is issued while in self-refresh, even past the refresh deadline. Once `sr_req` falls, SELFX (code 3) appears in the next cycle with `cke` high.
- R6: After SELFX, `grant_nonrd` and `grant_act` rise exactly T_SNR cycles after the SELFX cycle. `grant_rd` rises exactly T_SRD cycles after it (200 by default).
- R7: SELFX restarts the refresh timer, so the next REF appears exactly REFI_CYC cycles after the SELFX cycle.
- R8: PDEN (code 4) drives `cke` low. PDEX (code 5) never appears in the cycle right after PDEN. All grants stay low from PDEN until T_PDX+1 cycles after PDEX.
- R9: While in power-down with `pd_req` held, PDEX is issued on the block's own initiative exactly REFI_CYC−PD_LEAD cycles after the previous REF. The REF follows at its normal deadline. PDEN follows two cycles after the refresh window T_RFC closes.
- R10: A refresh deadline has priority over a power-down request. PDEN is not issued while the refresh is fewer than PD_LEAD+1 cycles from due.
- R11: At most one strobe per cycle, using NOP=0, REF=1, SELF=2, SELFX=3, PDEN=4, PDEX=5. The `cke` level rises only together with SELFX or PDEX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| banks_idle | input | 1 | Scheduler reports all banks precharged and idle |
| sr_req | input | 1 | Host level: high requests self-refresh, low requests exit |
| pd_req | input | 1 | Host level: high requests power-down, low requests exit |
| cmd | output | 3 | Command strobe code, NOP when no command |
| cke | output | 1 | Clock-enable level to the memory |
| grant_act | output | 1 | Activate and mode-register commands allowed |
| grant_nonrd | output | 1 | Other non-read commands allowed |
| grant_rd | output | 1 | Read commands allowed |
| busy | output | 1 | A refresh or entry request is waiting for idle banks |

## Verification
The bench targets the cycle after SELFX. A design with one shared wake-up window would raise the read grant at T_SNR instead of 200 cycles. It also holds a power-down request across several refresh deadlines. A design that stays asleep would miss the REF, and one that wakes late or early would shift PDEX away from its exact cycle. A power-down request arrives on the very edge where the refresh falls due. A design without refresh priority would issue PDEN first. Busy banks are held across a deadline and across a self-refresh request, which catches a design that issues commands to active banks or never raises `busy`. The bench also drops `pd_req` in the PDEN cycle, which catches a design that issues PDEX back to back with PDEN.

// File: rtl/pwrseq_pkg.sv
`timescale 1ns/1ps
// Shared command codes and sequencer states for the refresh/power sequencer.
// Assumes a three-bit command bus decoded by the memory-facing logic.
package pwrseq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_REF   = 3'd1,
        CMD_SELF  = 3'd2,
        CMD_SELFX = 3'd3,
        CMD_PDEN  = 3'd4,
        CMD_PDEX  = 3'd5
    } pwr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REFRESHING,
        ST_SELF_REFRESH,
        ST_SR_EXIT_WAIT,
        ST_POWER_DOWN,
        ST_PD_EXIT_WAIT
    } pwr_state_e;

endpackage

// File: rtl/pwrseq_refi_timer.sv
`timescale 1ns/1ps
// Refresh interval timer. Counts cycles since the last restart and saturates.
// 'due' is high once REFI_CYC-1 cycles have passed since the restart.
// 'near' is high once the count is within PD_LEAD cycles of 'due'.
// Assumes REFI_CYC >= 2 and PD_LEAD < REFI_CYC-1.
module pwrseq_refi_timer #(
    parameter int REFI_CYC = 3900,
    parameter int PD_LEAD  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic due,
    output logic near
);
    localparam int CW = $clog2(REFI_CYC);
    localparam logic [CW-1:0] LAST    = CW'(REFI_CYC - 1);
    localparam logic [CW-1:0] NEAR_AT = CW'(REFI_CYC - 1 - PD_LEAD);

    logic [CW-1:0] cnt_q;

    // Count cycles since the last restart, holding at the due value.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (restart)         cnt_q <= '0;
        else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
    end

    assign due  = (cnt_q == LAST);
    assign near = (cnt_q >= NEAR_AT);

    assert_restart_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !due)
        else $error("refresh timer still due after restart");

endmodule

// File: rtl/pwrseq_holdoff.sv
`timescale 1ns/1ps
// Hold-off window counter. A load starts a countdown from load_val.
// 'done' is high whenever the count is zero.
// Assumes load is a single-cycle pulse from the sequencer.
module pwrseq_holdoff #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             done
);
    logic [WIDTH-1:0] cnt_q;

    // Load a new window or count the running one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    assert_window_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !done)
        else $error("hold-off window did not start on load");

endmodule

// File: rtl/dram_pwr_refresh_seq.sv
`timescale 1ns/1ps
// Refresh and power-state sequencer for a DDR SDRAM controller.
// Issues periodic REF and the self-refresh and power-down command sequences,
// drives CKE, and gives grants to the main scheduler.
// Assumes the scheduler issues nothing unless granted and reports banks_idle
// truthfully. Assumes PD_LEAD > T_PDX + 1 and all windows >= 1.
module dram_pwr_refresh_seq #(
    parameter int CLK_MHZ = 250,
    parameter int REFI_NS = 15600,
    parameter int T_RFC   = 30,
    parameter int T_SNR   = 32,
    parameter int T_SRD   = 200,
    parameter int T_PDX   = 1,
    parameter int PD_LEAD = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       banks_idle,
    input  logic       sr_req,
    input  logic       pd_req,
    output logic [2:0] cmd,
    output logic       cke,
    output logic       grant_act,
    output logic       grant_nonrd,
    output logic       grant_rd,
    output logic       busy
);
    import pwrseq_pkg::*;

    localparam int REFI_CYC = REFI_NS * CLK_MHZ / 1000;
    localparam int NWIN  = 4;
    localparam int W_RFC = 0;
    localparam int W_SNR = 1;
    localparam int W_SRD = 2;
    localparam int W_PDX = 3;
    localparam int M1    = (T_RFC > T_SNR) ? T_RFC : T_SNR;
    localparam int M2    = (T_SRD > T_PDX) ? T_SRD : T_PDX;
    localparam int TMAX  = (M1 > M2) ? M1 : M2;
    localparam int HW    = $clog2(TMAX + 1);

    pwr_state_e     state_q, state_d;
    pwr_cmd_e       cmd_q, cmd_d;
    logic           cke_q, cke_d;
    logic           restart, due, near;
    logic [NWIN-1:0] win_load, win_done;

    pwrseq_refi_timer #(.REFI_CYC(REFI_CYC), .PD_LEAD(PD_LEAD)) u_refi (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .due     (due),
        .near    (near)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam int LEN = (g == W_RFC) ? T_RFC :
                             (g == W_SNR) ? T_SNR :
                             (g == W_SRD) ? T_SRD : T_PDX;
        pwrseq_holdoff #(.WIDTH(HW)) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (win_load[g]),
            .load_val (HW'(LEN)),
            .done     (win_done[g])
        );
    end

    // Choose the next state and the strobe; refresh outranks host requests.
    always_comb begin
        state_d  = state_q;
        cmd_d    = CMD_NOP;
        cke_d    = cke_q;
        restart  = 1'b0;
        win_load = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (due && banks_idle) begin
                    cmd_d = CMD_REF;  state_d = ST_REFRESHING;
                    restart = 1'b1;   win_load[W_RFC] = 1'b1;
                end else if (!due && sr_req && banks_idle) begin
                    cmd_d = CMD_SELF; state_d = ST_SELF_REFRESH; cke_d = 1'b0;
                end else if (!due && !near && pd_req && banks_idle) begin
                    cmd_d = CMD_PDEN; state_d = ST_POWER_DOWN;   cke_d = 1'b0;
                end
            end
            ST_REFRESHING:
                if (win_done[W_RFC]) state_d = ST_IDLE;
            ST_SELF_REFRESH:
                if (!sr_req && cmd_q == CMD_NOP) begin
                    cmd_d = CMD_SELFX; state_d = ST_SR_EXIT_WAIT; cke_d = 1'b1;
                    restart = 1'b1;
                    win_load[W_SNR] = 1'b1; win_load[W_SRD] = 1'b1;
                end
            ST_SR_EXIT_WAIT:
                if (win_done[W_SNR]) state_d = ST_IDLE;
            ST_POWER_DOWN:
                if (cmd_q == CMD_NOP && (!pd_req || near)) begin
                    cmd_d = CMD_PDEX; state_d = ST_PD_EXIT_WAIT; cke_d = 1'b1;
                    win_load[W_PDX] = 1'b1;
                end
            ST_PD_EXIT_WAIT:
                if (win_done[W_PDX]) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Register state, strobe and clock-enable level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= CMD_NOP;
            cke_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
            cke_q   <= cke_d;
        end
    end

    // Decode scheduler grants from the state and the open windows.
    always_comb begin
        grant_nonrd = win_done[W_SNR] && cmd_q == CMD_NOP &&
                      (state_q == ST_IDLE || state_q == ST_REFRESHING ||
                       state_q == ST_SR_EXIT_WAIT);
        grant_act   = grant_nonrd && win_done[W_RFC];
        grant_rd    = grant_nonrd && win_done[W_SRD] && state_q != ST_REFRESHING;
    end

    assign busy = (state_q == ST_IDLE) && !banks_idle &&
                  (due || sr_req || (pd_req && !near));
    assign cmd  = cmd_q;
    assign cke  = cke_q;

    assert_banks_idle_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q inside {CMD_REF, CMD_SELF, CMD_PDEN}) |-> $past(banks_idle))
        else $error("command issued while banks were busy");

    assert_rfc_blocks_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_REF) |=> !grant_act)
        else $error("activate granted inside refresh window");

    assert_no_ref_asleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_q |-> (cmd_q != CMD_REF))
        else $error("refresh issued with clock enable low");

    assert_pd_min_stay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PDEN) |=> (cmd_q != CMD_PDEX))
        else $error("power-down exit right after entry");

    assert_read_relock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_SELFX) |=> !grant_rd)
        else $error("read granted right after self-refresh exit");

    assert_cke_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_q && !$past(cke_q)) |-> (cmd_q inside {CMD_SELFX, CMD_PDEX}))
        else $error("clock enable rose without an exit strobe");

endmodule

// File: tb/dram_pwr_refresh_seq_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected strobes and levels by cycle,
// and a monitor compares them against the outputs at each falling edge.
module dram_pwr_refresh_seq_test;
    import pwrseq_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0;
    logic banks_idle = 1'b1, sr_req = 1'b0, pd_req = 1'b0;
    logic [2:0] cmd;
    logic cke, grant_act, grant_nonrd, grant_rd, busy;

    int cyc = 0, checks = 0, errors = 0;
    bit finished = 1'b0;

    typedef struct { int at; logic [2:0] code; logic cke_lvl; string tag; } strobe_t;
    typedef struct { int at; int sig; logic lvl; string tag; } level_t;
    strobe_t strobe_q[$];
    level_t  level_q[$];

    dram_pwr_refresh_seq #(
        .CLK_MHZ(250), .REFI_NS(2000), .T_RFC(16), .T_SNR(24),
        .T_SRD(200), .T_PDX(2), .PD_LEAD(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .sr_req(sr_req),
        .pd_req(pd_req), .cmd(cmd), .cke(cke), .grant_act(grant_act),
        .grant_nonrd(grant_nonrd), .grant_rd(grant_rd), .busy(busy)
    );

    always #2 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic exp_strobe(int at, pwr_cmd_e code, logic cl, string tag);
        strobe_t s;
        s.at = at; s.code = code; s.cke_lvl = cl; s.tag = tag;
        strobe_q.push_back(s);
    endtask

    task automatic exp_level(int at, int sig, logic lvl, string tag);
        level_t l;
        l.at = at; l.sig = sig; l.lvl = lvl; l.tag = tag;
        level_q.push_back(l);
    endtask

    function automatic logic pick(int sig);
        case (sig)
            0: return cke;
            1: return grant_act;
            2: return grant_nonrd;
            3: return grant_rd;
            default: return busy;
        endcase
    endfunction

    function automatic string sig_name(int sig);
        case (sig)
            0: return "cke";
            1: return "grant_act";
            2: return "grant_nonrd";
            3: return "grant_rd";
            default: return "busy";
        endcase
    endfunction

    task automatic at_cycle(int n);
        while (cyc != n) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Monitor: pop and compare strobes and levels as the design produces them.
    always @(negedge clk) begin
        strobe_t s;
        level_t  l;
        if (rst_n && !finished) begin
            if (cmd != CMD_NOP) begin
                checks++;
                if (strobe_q.size() == 0) begin
                    errors++;
                    $display("FAIL R11 unexpected strobe at cycle %0d: actual cmd=%0d expected none",
                             cyc, cmd);
                end else begin
                    s = strobe_q.pop_front();
                    if (s.at != cyc || s.code != cmd || s.cke_lvl != cke) begin
                        errors++;
                        $display("FAIL %s strobe: actual cmd=%0d cycle=%0d cke=%0b expected cmd=%0d cycle=%0d cke=%0b",
                                 s.tag, cmd, cyc, cke, s.code, s.at, s.cke_lvl);
                    end
                end
            end
            while (level_q.size() > 0 && level_q[0].at == cyc) begin
                l = level_q.pop_front();
                checks++;
                if (pick(l.sig) !== l.lvl) begin
                    errors++;
                    $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b",
                             l.tag, sig_name(l.sig), cyc, pick(l.sig), l.lvl);
                end
            end
        end
    end

    // Driver: queue expectations, then apply the stimulus timeline.
    initial begin
        // Strobes in order: cycle, code, cke level in that cycle.
        exp_strobe(500,  CMD_REF,   1'b1, "R2");
        exp_strobe(1011, CMD_REF,   1'b1, "R4");
        exp_strobe(1511, CMD_REF,   1'b1, "R10");
        exp_strobe(1529, CMD_PDEN,  1'b0, "R10");
        exp_strobe(2003, CMD_PDEX,  1'b1, "R9");
        exp_strobe(2011, CMD_REF,   1'b1, "R9");
        exp_strobe(2029, CMD_PDEN,  1'b0, "R9");
        exp_strobe(2031, CMD_PDEX,  1'b1, "R8");
        exp_strobe(2101, CMD_SELF,  1'b0, "R5");
        exp_strobe(2701, CMD_SELFX, 1'b1, "R5");
        exp_strobe(3201, CMD_REF,   1'b1, "R7");
        exp_strobe(3311, CMD_SELF,  1'b0, "R4");
        exp_strobe(3321, CMD_SELFX, 1'b1, "R5");
        exp_strobe(3821, CMD_REF,   1'b1, "R7");
        // Levels: 0 cke, 1 grant_act, 2 grant_nonrd, 3 grant_rd, 4 busy.
        exp_level(1, 0, 1'b1, "R1"); exp_level(1, 1, 1'b1, "R1");
        exp_level(1, 2, 1'b1, "R1"); exp_level(1, 3, 1'b1, "R1");
        exp_level(1, 4, 1'b0, "R1");
        exp_level(500, 1, 1'b0, "R3"); exp_level(500, 2, 1'b0, "R3");
        exp_level(501, 2, 1'b1, "R3"); exp_level(515, 1, 1'b0, "R3");
        exp_level(516, 1, 1'b1, "R3"); exp_level(516, 3, 1'b0, "R3");
        exp_level(517, 3, 1'b1, "R3");
        exp_level(998, 4, 1'b0, "R4"); exp_level(999, 4, 1'b1, "R4");
        exp_level(1005, 4, 1'b1, "R4"); exp_level(1011, 4, 1'b0, "R4");
        exp_level(1600, 0, 1'b0, "R8"); exp_level(1600, 2, 1'b0, "R8");
        exp_level(2002, 0, 1'b0, "R9"); exp_level(2003, 0, 1'b1, "R9");
        exp_level(2005, 2, 1'b0, "R8"); exp_level(2006, 2, 1'b1, "R8");
        exp_level(2033, 2, 1'b0, "R8"); exp_level(2034, 2, 1'b1, "R8");
        exp_level(2300, 0, 1'b0, "R5"); exp_level(2300, 3, 1'b0, "R5");
        exp_level(2600, 0, 1'b0, "R5");
        exp_level(2701, 0, 1'b1, "R5"); exp_level(2701, 2, 1'b0, "R6");
        exp_level(2724, 1, 1'b0, "R6"); exp_level(2724, 2, 1'b0, "R6");
        exp_level(2725, 1, 1'b1, "R6"); exp_level(2725, 2, 1'b1, "R6");
        exp_level(2725, 3, 1'b0, "R6");
        exp_level(2900, 3, 1'b0, "R6"); exp_level(2901, 3, 1'b1, "R6");
        exp_level(3300, 4, 1'b1, "R4"); exp_level(3305, 4, 1'b1, "R4");
        exp_level(3310, 4, 1'b0, "R4");
        exp_level(3520, 3, 1'b0, "R6"); exp_level(3521, 3, 1'b1, "R6");

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        at_cycle(990);  banks_idle = 1'b0;          // R4: hold the deadline
        at_cycle(1010); banks_idle = 1'b1;
        at_cycle(1510); pd_req = 1'b1;              // R10: same edge as due
        at_cycle(2029); pd_req = 1'b0;              // R8: drop in PDEN cycle
        at_cycle(2100); sr_req = 1'b1;              // R5: long self-refresh
        at_cycle(2700); sr_req = 1'b0;
        at_cycle(3300); banks_idle = 1'b0; sr_req = 1'b1;   // R4: busy entry
        at_cycle(3310); banks_idle = 1'b1;
        at_cycle(3320); sr_req = 1'b0;
        at_cycle(3900);

        checks++;
        if (strobe_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing strobes: actual pending=%0d expected 0 (next cycle %0d)",
                     strobe_q.size(), strobe_q[0].at);
        end
        checks++;
        if (level_q.size() != 0) begin
            errors++;
            $display("FAIL R1 unchecked levels: actual pending=%0d expected 0", level_q.size());
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (10000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R11 watchdog: actual=hung expected=finished by cycle 3900");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule